// File: doc/BRIEF.md
# Accumulator-Fed Multi-Unit ALU Datapath

This block is a 16-bit accumulator datapath in which the accumulator sits after the arithmetic and logic unit. Sixteen combinational function units all see the same two operands at all times. The first operand is the internal data bus. The second is the present accumulator value. A 4-bit select code enables exactly one unit, and that unit's output alone reaches a shared result bus. When the load strobe is high, the accumulator captures the result bus on the next clock edge. The carry, zero and sign flags are captured on the same edge.

Neither operand is held in a temporary register, so the result bus follows the operands and the select code within the same cycle. Because unit 0 forwards the data bus unchanged, the accumulator can be loaded like an ordinary register. The accumulator output goes back onto the data bus to move its value to other registers. The accumulator is the only place an arithmetic or logic result can be written.

Top module: `accu_alu_dp`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and the carry, zero and sign flags to 0 on the next clock edge. Reset takes precedence over a load in the same cycle.
- R2: While the load strobe is low, the accumulator and all flags keep their values, whatever the select code and data bus do.
- R3: Select code 0 places the data bus unchanged on the result bus and ignores the accumulator. A load with code 0 clears carry.
- R4: Codes 1 (add) and 2 (add with carry-in) produce acc + bus and acc + bus + carry. Carry is the bit-16 carry out.
- R5: Codes 3 (subtract) and 4 (subtract with borrow-in) produce acc - bus and acc - bus - carry. Carry is set when a borrow occurs.
- R6: Codes 5, 6 and 7 produce acc AND bus, acc OR bus and acc XOR bus, and clear carry.
- R7: Codes 8 to 15 ignore the data bus and act on the accumulator alone:
  - 8 inverts it, with carry 0.
  - 9 shifts it left, with carry set to the old bit 15.
  - 10 shifts it right logically, with carry set to the old bit 0.
  - 11 adds one, with carry set when the old value was FFFF.
  - 12 subtracts one, with carry set when the old value was 0.
  - 13 passes it unchanged, with carry 0.
  - 14 negates it in two's complement, with carry set when it was nonzero.
  - 15 gives 0, with carry 0.
- R8: On each load, the zero flag becomes 1 exactly when the loaded value is 0, and the sign flag becomes bit 15 of the loaded value.
- R9: The result bus shows the selected unit's output for the current operands in the same cycle, and a load stores exactly that value.
- R10: Exactly one function unit is enabled onto the result bus for every select code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbus_i | input | 16 | Internal data bus operand |
| fsel_i | input | 4 | Function unit select code |
| load_i | input | 1 | Accumulator and flag load strobe |
| rbus_o | output | 16 | Result bus (selected unit output) |
| acc_o | output | 16 | Accumulator value |
| carry_o | output | 1 | Carry / borrow flag |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |

## Verification
Two things can happen in the same cycle.

The first is reset together with a load strobe. The bench raises reset while the load is high and a unit with a nonzero result and a set carry is selected. It then expects the accumulator and all three flags to read zero after that edge.

The second is a change of select code or data bus while the load is low. After every operation, the bench drops the load, inverts both the select code and the data bus, and expects the accumulator and flags to be unchanged after the next edge.

// File: rtl/accu_alu_pkg.sv
package accu_alu_pkg;

    localparam int DATA_W  = 16;
    localparam int SEL_W   = 4;
    localparam int N_UNITS = 1 << SEL_W;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        FN_PASS_D = 4'd0,
        FN_ADD    = 4'd1,
        FN_ADC    = 4'd2,
        FN_SUB    = 4'd3,
        FN_SBB    = 4'd4,
        FN_AND    = 4'd5,
        FN_OR     = 4'd6,
        FN_XOR    = 4'd7,
        FN_NOT_A  = 4'd8,
        FN_SHL_A  = 4'd9,
        FN_SHR_A  = 4'd10,
        FN_INC_A  = 4'd11,
        FN_DEC_A  = 4'd12,
        FN_PASS_A = 4'd13,
        FN_NEG_A  = 4'd14,
        FN_ZERO   = 4'd15
    } fn_code_e;

    typedef struct packed {
        logic  carry;
        word_t value;
    } unit_out_t;

    typedef struct packed {
        logic carry;
        logic zero;
        logic sign;
    } flags_t;

    // One function unit; operand d is the data bus, a the accumulator.
    function automatic unit_out_t unit_eval(fn_code_e code, word_t d, word_t a, logic cin);
        unit_out_t        r;
        logic [DATA_W:0]  wide;
        r    = '0;
        wide = '0;
        unique case (code)
            FN_PASS_D: r.value = d;
            FN_ADD: begin
                wide = {1'b0, a} + {1'b0, d};
                r    = {wide[DATA_W], wide[DATA_W-1:0]};
            end
            FN_ADC: begin
                wide = {1'b0, a} + {1'b0, d} + {{DATA_W{1'b0}}, cin};
                r    = {wide[DATA_W], wide[DATA_W-1:0]};
            end
            FN_SUB: begin
                wide = {1'b0, a} - {1'b0, d};
                r    = {wide[DATA_W], wide[DATA_W-1:0]};
            end
            FN_SBB: begin
                wide = {1'b0, a} - {1'b0, d} - {{DATA_W{1'b0}}, cin};
                r    = {wide[DATA_W], wide[DATA_W-1:0]};
            end
            FN_AND:    r.value = a & d;
            FN_OR:     r.value = a | d;
            FN_XOR:    r.value = a ^ d;
            FN_NOT_A:  r.value = ~a;
            FN_SHL_A:  r = {a[DATA_W-1], a[DATA_W-2:0], 1'b0};
            FN_SHR_A:  r = {a[0], 1'b0, a[DATA_W-1:1]};
            FN_INC_A: begin
                wide = {1'b0, a} + 1'b1;
                r    = {wide[DATA_W], wide[DATA_W-1:0]};
            end
            FN_DEC_A: begin
                wide = {1'b0, a} - 1'b1;
                r    = {wide[DATA_W], wide[DATA_W-1:0]};
            end
            FN_PASS_A: r.value = a;
            FN_NEG_A: begin
                wide = {(DATA_W+1){1'b0}} - {1'b0, a};
                r    = {wide[DATA_W], wide[DATA_W-1:0]};
            end
            FN_ZERO:   r = '0;
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/accu_fn_bank.sv
module accu_fn_bank
    import accu_alu_pkg::*;
#(
    parameter int UNITS = N_UNITS
) (
    input  word_t                 opd_bus,
    input  word_t                 opd_acc,
    input  logic                  carry_in,
    output unit_out_t [UNITS-1:0] unit_res
);

    // Every unit is fed continuously from both operands; none is registered.
    for (genvar g = 0; g < UNITS; g++) begin : g_unit
        localparam fn_code_e UNIT_CODE = fn_code_e'(g);
        assign unit_res[g] = unit_eval(UNIT_CODE, opd_bus, opd_acc, carry_in);
    end

endmodule

// File: rtl/accu_sel_decode.sv
module accu_sel_decode
    import accu_alu_pkg::*;
#(
    parameter int SW    = SEL_W,
    localparam int UNITS = 1 << SW
) (
    input  logic [SW-1:0]    sel,
    output logic [UNITS-1:0] enable
);

    always_comb begin
        enable      = '0;
        enable[sel] = 1'b1;
    end

endmodule

// File: rtl/accu_result_mux.sv
module accu_result_mux
    import accu_alu_pkg::*;
#(
    parameter int UNITS = N_UNITS
) (
    input  logic      [UNITS-1:0] enable,
    input  unit_out_t [UNITS-1:0] unit_res,
    output unit_out_t             bus_out
);

    // AND-OR bus: a disabled unit contributes all zeros.
    always_comb begin
        bus_out = '0;
        for (int u = 0; u < UNITS; u++) begin
            if (enable[u]) begin
                bus_out = unit_out_t'(bus_out | unit_res[u]);
            end
        end
    end

endmodule

// File: rtl/accu_state_reg.sv
module accu_state_reg
    import accu_alu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  unit_out_t bus_in,
    output word_t     acc_q,
    output flags_t    flags_q
);

    flags_t flags_d;

    always_comb begin
        flags_d.carry = bus_in.carry;
        flags_d.zero  = (bus_in.value == '0);
        flags_d.sign  = bus_in.value[DATA_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            flags_q <= '0;
        end else if (load) begin
            acc_q   <= bus_in.value;
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/accu_alu_dp.sv
module accu_alu_dp
    import accu_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] dbus_i,
    input  logic [SEL_W-1:0]  fsel_i,
    input  logic              load_i,
    output logic [DATA_W-1:0] rbus_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              carry_o,
    output logic              zero_o,
    output logic              sign_o
);

    unit_out_t [N_UNITS-1:0] unit_res;
    logic      [N_UNITS-1:0] unit_en;
    unit_out_t               result_bus;
    word_t                   acc_q;
    flags_t                  flags_q;

    accu_fn_bank #(.UNITS(N_UNITS)) u_bank (
        .opd_bus  (dbus_i),
        .opd_acc  (acc_q),
        .carry_in (flags_q.carry),
        .unit_res (unit_res)
    );

    accu_sel_decode #(.SW(SEL_W)) u_dec (
        .sel    (fsel_i),
        .enable (unit_en)
    );

    accu_result_mux #(.UNITS(N_UNITS)) u_mux (
        .enable   (unit_en),
        .unit_res (unit_res),
        .bus_out  (result_bus)
    );

    accu_state_reg u_state (
        .clk     (clk),
        .rst     (rst),
        .load    (load_i),
        .bus_in  (result_bus),
        .acc_q   (acc_q),
        .flags_q (flags_q)
    );

    assign rbus_o  = result_bus.value;
    assign acc_o   = acc_q;
    assign carry_o = flags_q.carry;
    assign zero_o  = flags_q.zero;
    assign sign_o  = flags_q.sign;

endmodule

// File: rtl/accu_alu_chk.sv
module accu_alu_chk
    import accu_alu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] dbus_i,
    input logic [SEL_W-1:0]  fsel_i,
    input logic              load_i,
    input logic [DATA_W-1:0] rbus_o,
    input logic [DATA_W-1:0] acc_o,
    input logic              carry_o,
    input logic              zero_o,
    input logic              sign_o,
    input logic [N_UNITS-1:0] unit_en
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && !carry_o && !zero_o && !sign_o));

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(acc_o) && $stable({carry_o, zero_o, sign_o})));

    assert_pass_bus_R3: assert property (@(posedge clk) disable iff (rst)
        (load_i && fsel_i == 4'd0) |=> (acc_o == $past(dbus_i) && !carry_o));

    assert_logic_clears_carry_R6: assert property (@(posedge clk) disable iff (rst)
        (load_i && fsel_i >= 4'd5 && fsel_i <= 4'd7) |=> !carry_o);

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (zero_o == (acc_o == '0)));

    assert_sign_flag_R8: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (sign_o == acc_o[DATA_W-1]));

    assert_bus_to_acc_R9: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (acc_o == $past(rbus_o)));

    assert_single_driver_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(unit_en) == 1);

endmodule

bind accu_alu_dp accu_alu_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .dbus_i  (dbus_i),
    .fsel_i  (fsel_i),
    .load_i  (load_i),
    .rbus_o  (rbus_o),
    .acc_o   (acc_o),
    .carry_o (carry_o),
    .zero_o  (zero_o),
    .sign_o  (sign_o),
    .unit_en (unit_en)
);

// File: tb/accu_alu_dp_bench.sv
module accu_alu_dp_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] dbus_i = '0;
    logic [3:0]  fsel_i = '0;
    logic        load_i = 1'b0;
    logic [15:0] rbus_o;
    logic [15:0] acc_o;
    logic        carry_o;
    logic        zero_o;
    logic        sign_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    accu_alu_dp u_accu_alu_dp (
        .clk     (clk),
        .rst     (rst),
        .dbus_i  (dbus_i),
        .fsel_i  (fsel_i),
        .load_i  (load_i),
        .rbus_o  (rbus_o),
        .acc_o   (acc_o),
        .carry_o (carry_o),
        .zero_o  (zero_o),
        .sign_o  (sign_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference: {carry, result} from the requirement text.
    function automatic logic [16:0] model(int code, logic [15:0] d, logic [15:0] a, logic cin);
        int unsigned ai = a;
        int unsigned di = d;
        int unsigned ci = cin;
        int unsigned s;
        case (code)
            0:  return {1'b0, d};
            1:  begin s = ai + di;      return {s > 32'hFFFF, s[15:0]}; end
            2:  begin s = ai + di + ci; return {s > 32'hFFFF, s[15:0]}; end
            3:  return {ai < di, a - d};
            4:  return {ai < di + ci, a - d - {15'd0, cin}};
            5:  return {1'b0, a & d};
            6:  return {1'b0, a | d};
            7:  return {1'b0, a ^ d};
            8:  return {1'b0, ~a};
            9:  return {a[15], a << 1};
            10: return {a[0], a >> 1};
            11: return {a == 16'hFFFF, a + 16'd1};
            12: return {a == 16'h0000, a - 16'd1};
            13: return {1'b0, a};
            14: return {a != 16'h0000, 16'd0 - a};
            default: return 17'd0;
        endcase
    endfunction

    function automatic string req_of(int code);
        if (code == 0) return "R3";
        if (code <= 2) return "R4";
        if (code <= 4) return "R5";
        if (code <= 7) return "R6";
        return "R7";
    endfunction

    function automatic logic [15:0] pick(int i);
        case (i)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'h7FFF;
            3: return 16'h8000;  4: return 16'hFFFF;  5: return 16'hFFFE;
            6: return 16'h1234;  7: return 16'hA5A5;  8: return 16'h5A5A;
            9: return 16'h00FF;  10: return 16'hFF00; default: return 16'h8001;
        endcase
    endfunction

    // Bring the accumulator to value a with carry flag cin.
    task automatic set_state(logic [15:0] a, logic cin);
        load_i = 1'b1;
        if (!cin) begin
            dbus_i = a; fsel_i = 4'd0; step();
        end else if (a != 16'hFFFF) begin
            dbus_i = 16'hFFFF; fsel_i = 4'd0; step();
            dbus_i = a + 16'd1; fsel_i = 4'd1; step();
        end else begin
            dbus_i = 16'h0000; fsel_i = 4'd0; step();
            dbus_i = 16'h0001; fsel_i = 4'd3; step();
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [16:0] exp;
        logic [15:0] held;
        logic [2:0]  held_f;
        rst = 1'b1;
        step();
        step();
        // R1: state after reset
        check("R1", "acc after reset", acc_o, 0);
        check("R1", "flags after reset", {carry_o, zero_o, sign_o}, 0);
        rst = 1'b0;

        for (int code = 0; code < 16; code++) begin
            for (int ia = 0; ia < 12; ia++) begin
                for (int id = 0; id < 12; id++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        logic [15:0] a = pick(ia);
                        logic [15:0] d = pick(id);
                        set_state(a, ci[0]);
                        check("R1", "carry preset", carry_o, ci);
                        exp = model(code, d, a, ci[0]);
                        dbus_i = d; fsel_i = code[3:0]; load_i = 1'b1;
                        #1;
                        // R9 / R10: only the selected unit appears on the result bus
                        check("R9", "result bus", rbus_o, exp[15:0]);
                        step();
                        check(req_of(code), "acc", acc_o, exp[15:0]);
                        check(req_of(code), "carry", carry_o, exp[16]);
                        check("R8", "zero", zero_o, exp[15:0] == 16'h0);
                        check("R8", "sign", sign_o, exp[15]);
                        // R2: idle load with everything else changing
                        held = acc_o; held_f = {carry_o, zero_o, sign_o};
                        load_i = 1'b0; fsel_i = ~code[3:0]; dbus_i = ~d;
                        step();
                        check("R2", "acc hold", acc_o, held);
                        check("R2", "flag hold", {carry_o, zero_o, sign_o}, held_f);
                    end
                end
            end
        end

        // R1: reset together with a load that would set carry and a value
        set_state(16'hFFFF, 1'b0);
        dbus_i = 16'h0002; fsel_i = 4'd1; load_i = 1'b1; rst = 1'b1;
        step();
        check("R1", "acc reset over load", acc_o, 0);
        check("R1", "flags reset over load", {carry_o, zero_o, sign_o}, 0);
        rst = 1'b0; load_i = 1'b0;
        step();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule